// File: doc/BRIEF.md
# Serial Control Port with Interface Latches

This block is the control-side front end of a telephony codec. A host talks to it over a four-wire serial link: an active-low select frames each transfer, a control clock shifts bits, one line carries bits in and another carries bits out. Every transfer is sixteen bits long. The first byte is an instruction that names a register and says whether to read or write it. The second byte is the data: it is captured on a write, or driven back to the host on a read.

Behind the port sit the codec's programmable state. This includes a mode register with the power-down, delayed-timing and amplifier-enable bits, transmit and receive gain words and a hybrid-balance word. A bank of six general-purpose latch pins is also kept here. Each latch pin is set as an input or an output by a direction register. Output pins drive the value last written into the latch register. Input pins are sampled into that register whenever a transfer completes. The whole port, shifting included, runs on the control clock, which need not be related to any other clock in the codec. An active-high master reset returns every register to its power-on value.

Top module: `ctl_serial_port`

## Requirements
- R1: A transfer is an instruction byte followed by a data byte, both MSB first, with `ci` sampled on rising `cclk` edges while `cs_n` is low. Bit 0 of the instruction selects read (1) or write (0). Bits 7..1 hold the register address: 0 mode, 1 transmit gain, 2 receive gain, 3 hybrid word, 4 latch register, 5 direction register.
- R2: A write updates the addressed register on the rising edge that samples the sixteenth bit, and the matching outputs show the new value from that edge on.
- R3: A read loads the register value when the instruction byte completes. It then drives that value MSB first on `co`, one bit per falling edge, starting at the falling edge after the eighth rising edge, with `co_oe` high for those eight bits.
- R4: `co_oe` is low whenever `cs_n` is high, during the instruction byte, and during the whole of a write transfer.
- R5: If `cs_n` goes high before the sixteenth bit, the partial transfer is discarded and no register changes. The next transfer starts from bit one.
- R6: Direction register bit i set to 1 makes latch pin i an output (`il_oe[i]`=1) that drives latch register bit i on `il_out[i]`. A 0 makes the pin an input.
- R7: When any transfer completes, latch register bits of input pins take the levels on `il_in`, and a written value applies only to output pins. A read of the latch register returns the stored bit for output pins and the `il_in` level, sampled when the instruction byte completes, for input pins, with bits 7..6 zero.
- R8: After reset the mode register is 0x80, meaning power-down is set (bit 7), delayed timing is clear (bit 6) and the amplifier is disabled (bit 5). The gain words are 0x00 (no output), the hybrid word is 0x00 (balance off), all latch pins are inputs with the latch register zero, and `co_oe` is low.
- R9: Raising `mr` for one cycle, even in the middle of a transfer, restores the R8 state and drops the transfer. The next full transfer works normally.
- R10: Gain, hybrid and latch registers accept writes while the power-down bit is set, and the power-down bit changes only through a write to the mode register.
- R11: A write to an unused address changes nothing, and a read from an unused address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Control clock; shifts serial data and clocks all registers |
| mr | input | 1 | Master reset, active high, synchronous to `cclk` |
| cs_n | input | 1 | Active-low transfer select |
| ci | input | 1 | Serial data into the port |
| co | output | 1 | Serial data out of the port |
| co_oe | output | 1 | Output enable for `co`; low means high impedance |
| il_in | input | 6 | Levels sensed on the latch pins |
| il_out | output | 6 | Values driven onto latch pins set as outputs |
| il_oe | output | 6 | Per-pin output enable for the latch pins |
| pwr_down | output | 1 | Power-down control bit |
| delayed_timing | output | 1 | Delayed timing mode bit |
| amp_en | output | 1 | Power amplifier enable |
| tx_gain | output | 8 | Transmit gain word |
| rx_gain | output | 8 | Receive gain word |
| hyb_ctrl | output | 8 | Hybrid balance control word |

## Verification
The hardest case to reach is the value that lands in a latch register bit while its pin is an input. That stored bit never reaches a port until the pin is turned into an output. The stimulus writes the latch register, changes `il_in`, performs a read, and then changes `il_in` again just before rewriting the direction register. The `il_out` levels seen after the direction change can only match if capture happened at the completion of that last transfer. Partial frames and a master reset asserted after ten bits of a write are then driven with `cs_n` still low, so the discard paths are exercised as well.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;

  localparam int CP_DW = 8;                     // data and instruction byte width
  localparam int CP_AW = CP_DW - 1;             // address field width
  localparam int CP_CW = $clog2(2 * CP_DW);     // bit counter width
  localparam int CP_IW = $clog2(CP_DW);         // bit index within a byte

  typedef struct packed {
    logic [CP_AW-1:0] addr;
    logic             rd;
  } cp_instr_t;

  typedef enum logic [CP_AW-1:0] {
    A_MODE = 7'd0,
    A_TXG  = 7'd1,
    A_RXG  = 7'd2,
    A_HYB  = 7'd3,
    A_ILR  = 7'd4,
    A_LDR  = 7'd5
  } cp_addr_e;

  localparam int MODE_PD_BIT  = 7;
  localparam int MODE_DLY_BIT = 6;
  localparam int MODE_AMP_BIT = 5;

  localparam logic [CP_DW-1:0] MODE_RST = CP_DW'(1) << MODE_PD_BIT;
  localparam logic [CP_DW-1:0] GAIN_RST = '0;
  localparam logic [CP_DW-1:0] HYB_RST  = '0;

endpackage

// File: rtl/cp_shifter.sv
module cp_shifter
  import ctl_port_pkg::*;
(
  input  logic                  cclk,
  input  logic                  mr,
  input  logic                  cs_n,
  input  logic                  ci,
  output logic [CP_CW-1:0]      bit_cnt,
  output cp_instr_t             instr_now,
  output logic                  instr_stb,
  output cp_instr_t             instr_q,
  output logic                  xfer_stb,
  output logic [CP_DW-1:0]      data_now
);

  localparam logic [CP_CW-1:0] INSTR_LAST = CP_CW'(CP_DW - 1);
  localparam logic [CP_CW-1:0] XFER_LAST  = CP_CW'(2 * CP_DW - 1);

  logic [CP_DW-2:0] sh_q;

  // bit counter: cleared by reset or by a high select, wraps after a full frame
  always_ff @(posedge cclk) begin
    if (mr || cs_n) begin
      bit_cnt <= '0;
    end else if (bit_cnt == XFER_LAST) begin
      bit_cnt <= '0;
    end else begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge cclk) begin
    if (mr) begin
      sh_q <= '0;
    end else if (!cs_n) begin
      sh_q <= {sh_q[CP_DW-3:0], ci};
    end
  end

  assign data_now  = {sh_q, ci};
  assign instr_now = cp_instr_t'(data_now);
  assign instr_stb = !mr && !cs_n && (bit_cnt == INSTR_LAST);
  assign xfer_stb  = !mr && !cs_n && (bit_cnt == XFER_LAST);

  // the instruction of the frame in progress; reset to a write so nothing is driven
  always_ff @(posedge cclk) begin
    if (mr) begin
      instr_q <= '0;
    end else if (instr_stb) begin
      instr_q <= instr_now;
    end
  end

  // R5: a high select always restarts the frame
  p_cs_abort_r5: assert property (@(posedge cclk) disable iff (mr)
    cs_n |=> (bit_cnt == '0));

  // R1: one bit per rising edge while selected
  p_cnt_step_r1: assert property (@(posedge cclk) disable iff (mr)
    (!cs_n && bit_cnt != XFER_LAST) |=> (bit_cnt == $past(bit_cnt) + 1'b1));

endmodule

// File: rtl/cp_latch_bank.sv
module cp_latch_bank
  import ctl_port_pkg::*;
#(
  parameter int NL = 6
) (
  input  logic          cclk,
  input  logic          mr,
  input  logic          xfer_stb,
  input  logic          wr_ilr,
  input  logic          wr_ldr,
  input  logic [NL-1:0] wdata,
  input  logic [NL-1:0] il_in,
  output logic [NL-1:0] ilr_q,
  output logic [NL-1:0] ldr_q,
  output logic [NL-1:0] rd_view
);

  for (genvar i = 0; i < NL; i++) begin : g_pin
    always_ff @(posedge cclk) begin
      if (mr) begin
        ldr_q[i] <= 1'b0;
        ilr_q[i] <= 1'b0;
      end else begin
        if (wr_ldr) begin
          ldr_q[i] <= wdata[i];
        end
        if (wr_ilr && ldr_q[i]) begin
          ilr_q[i] <= wdata[i];
        end else if (xfer_stb && !ldr_q[i]) begin
          ilr_q[i] <= il_in[i];
        end
      end
    end

    assign rd_view[i] = ldr_q[i] ? ilr_q[i] : il_in[i];

    // R7: an output pin keeps its level until the latch register is written
    p_out_hold_r7: assert property (@(posedge cclk) disable iff (mr)
      (ldr_q[i] && !wr_ilr) |=> $stable(ilr_q[i]));
  end

  // R6: pin directions move only on a direction register write
  p_oe_hold_r6: assert property (@(posedge cclk) disable iff (mr)
    !wr_ldr |=> $stable(ldr_q));

endmodule

// File: rtl/cp_regfile.sv
module cp_regfile
  import ctl_port_pkg::*;
#(
  parameter int NL = 6
) (
  input  logic                cclk,
  input  logic                mr,
  input  logic                wr_stb,
  input  logic [CP_AW-1:0]    wr_addr,
  input  logic [CP_DW-1:0]    wdata,
  input  logic [CP_AW-1:0]    rd_addr,
  input  logic [NL-1:0]       ilr_view,
  input  logic [NL-1:0]       ldr_view,
  output logic                wr_ilr,
  output logic                wr_ldr,
  output logic [CP_DW-1:0]    rd_data,
  output logic [CP_DW-1:0]    mode_q,
  output logic [CP_DW-1:0]    txg_q,
  output logic [CP_DW-1:0]    rxg_q,
  output logic [CP_DW-1:0]    hyb_q
);

  localparam int PAD = CP_DW - NL;

  logic wr_mode, wr_txg, wr_rxg, wr_hyb;

  always_comb begin
    wr_mode = 1'b0;
    wr_txg  = 1'b0;
    wr_rxg  = 1'b0;
    wr_hyb  = 1'b0;
    wr_ilr  = 1'b0;
    wr_ldr  = 1'b0;
    if (wr_stb) begin
      case (wr_addr)
        A_MODE:  wr_mode = 1'b1;
        A_TXG:   wr_txg  = 1'b1;
        A_RXG:   wr_rxg  = 1'b1;
        A_HYB:   wr_hyb  = 1'b1;
        A_ILR:   wr_ilr  = 1'b1;
        A_LDR:   wr_ldr  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge cclk) begin
    if (mr) begin
      mode_q <= MODE_RST;
      txg_q  <= GAIN_RST;
      rxg_q  <= GAIN_RST;
      hyb_q  <= HYB_RST;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_txg)  txg_q  <= wdata;
      if (wr_rxg)  rxg_q  <= wdata;
      if (wr_hyb)  hyb_q  <= wdata;
    end
  end

  always_comb begin
    case (rd_addr)
      A_MODE:  rd_data = mode_q;
      A_TXG:   rd_data = txg_q;
      A_RXG:   rd_data = rxg_q;
      A_HYB:   rd_data = hyb_q;
      A_ILR:   rd_data = {{PAD{1'b0}}, ilr_view};
      A_LDR:   rd_data = {{PAD{1'b0}}, ldr_view};
      default: rd_data = '0;
    endcase
  end

  // R8: reset brings every control word to its power-on value
  p_reset_defaults_r8: assert property (@(posedge cclk)
    mr |=> (mode_q == MODE_RST && txg_q == GAIN_RST && rxg_q == GAIN_RST && hyb_q == HYB_RST));

  // R5: without a completed write no control word moves
  p_regs_hold_r5: assert property (@(posedge cclk) disable iff (mr)
    !wr_stb |=> ($stable(mode_q) && $stable(txg_q) && $stable(rxg_q) && $stable(hyb_q)));

endmodule

// File: rtl/cp_dout.sv
module cp_dout
  import ctl_port_pkg::*;
(
  input  logic                cclk,
  input  logic                mr,
  input  logic                cs_n,
  input  logic [CP_CW-1:0]    bit_cnt,
  input  logic                instr_stb,
  input  logic                instr_now_rd,
  input  logic                instr_rd,
  input  logic [CP_DW-1:0]    rd_data,
  output logic                co,
  output logic                co_oe
);

  localparam logic [CP_CW-1:0] XFER_LAST = CP_CW'(2 * CP_DW - 1);

  logic [CP_DW-1:0] rd_buf_q;
  logic             co_q;
  logic             oe_q;
  logic             rd_phase;
  logic [CP_CW-1:0] sel;

  // capture the read value as the instruction byte completes
  always_ff @(posedge cclk) begin
    if (mr) begin
      rd_buf_q <= '0;
    end else if (instr_stb && instr_now_rd) begin
      rd_buf_q <= rd_data;
    end
  end

  assign rd_phase = !cs_n && instr_rd && bit_cnt[CP_CW-1];
  assign sel      = XFER_LAST - bit_cnt;

  // output side moves on the falling edge
  always_ff @(negedge cclk) begin
    if (mr) begin
      co_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      oe_q <= rd_phase;
      if (rd_phase) begin
        co_q <= rd_buf_q[sel[CP_IW-1:0]];
      end
    end
  end

  assign co    = co_q;
  assign co_oe = oe_q && !cs_n;

  // R4: nothing is driven during an instruction byte or a write frame
  p_quiet_r4: assert property (@(posedge cclk) disable iff (mr)
    (bit_cnt < CP_CW'(CP_DW) || !instr_rd) |-> !oe_q);

endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
  import ctl_port_pkg::*;
#(
  parameter int NL = 6
) (
  input  logic                cclk,
  input  logic                mr,
  input  logic                cs_n,
  input  logic                ci,
  output logic                co,
  output logic                co_oe,
  input  logic [NL-1:0]       il_in,
  output logic [NL-1:0]       il_out,
  output logic [NL-1:0]       il_oe,
  output logic                pwr_down,
  output logic                delayed_timing,
  output logic                amp_en,
  output logic [CP_DW-1:0]    tx_gain,
  output logic [CP_DW-1:0]    rx_gain,
  output logic [CP_DW-1:0]    hyb_ctrl
);

  logic [CP_CW-1:0] bit_cnt;
  cp_instr_t        instr_now;
  cp_instr_t        instr_q;
  logic             instr_stb;
  logic             xfer_stb;
  logic [CP_DW-1:0] data_now;
  logic             wr_ilr, wr_ldr;
  logic [CP_DW-1:0] rd_data;
  logic [CP_DW-1:0] mode_q;
  logic [NL-1:0]    ilr_q, ldr_q, rd_view;

  cp_shifter u_shift (
    .cclk      (cclk),
    .mr        (mr),
    .cs_n      (cs_n),
    .ci        (ci),
    .bit_cnt   (bit_cnt),
    .instr_now (instr_now),
    .instr_stb (instr_stb),
    .instr_q   (instr_q),
    .xfer_stb  (xfer_stb),
    .data_now  (data_now)
  );

  cp_regfile #(.NL(NL)) u_regs (
    .cclk     (cclk),
    .mr       (mr),
    .wr_stb   (xfer_stb && !instr_q.rd),
    .wr_addr  (instr_q.addr),
    .wdata    (data_now),
    .rd_addr  (instr_now.addr),
    .ilr_view (rd_view),
    .ldr_view (ldr_q),
    .wr_ilr   (wr_ilr),
    .wr_ldr   (wr_ldr),
    .rd_data  (rd_data),
    .mode_q   (mode_q),
    .txg_q    (tx_gain),
    .rxg_q    (rx_gain),
    .hyb_q    (hyb_ctrl)
  );

  cp_latch_bank #(.NL(NL)) u_latch (
    .cclk     (cclk),
    .mr       (mr),
    .xfer_stb (xfer_stb),
    .wr_ilr   (wr_ilr),
    .wr_ldr   (wr_ldr),
    .wdata    (data_now[NL-1:0]),
    .il_in    (il_in),
    .ilr_q    (ilr_q),
    .ldr_q    (ldr_q),
    .rd_view  (rd_view)
  );

  cp_dout u_dout (
    .cclk         (cclk),
    .mr           (mr),
    .cs_n         (cs_n),
    .bit_cnt      (bit_cnt),
    .instr_stb    (instr_stb),
    .instr_now_rd (instr_now.rd),
    .instr_rd     (instr_q.rd),
    .rd_data      (rd_data),
    .co           (co),
    .co_oe        (co_oe)
  );

  assign il_out         = ilr_q;
  assign il_oe          = ldr_q;
  assign pwr_down       = mode_q[MODE_PD_BIT];
  assign delayed_timing = mode_q[MODE_DLY_BIT];
  assign amp_en         = mode_q[MODE_AMP_BIT];

  // R10: power-down only changes on a write to the mode register
  p_pd_hold_r10: assert property (@(posedge cclk) disable iff (mr)
    !(xfer_stb && !instr_q.rd && instr_q.addr == A_MODE) |=> $stable(pwr_down));

endmodule

// File: tb/test_ctl_serial_port.sv
module test_ctl_serial_port;

  logic       cclk = 1'b0;
  logic       mr = 1'b1;
  logic       cs_n = 1'b1;
  logic       ci = 1'b0;
  logic       co, co_oe;
  logic [5:0] il_in = '0;
  logic [5:0] il_out, il_oe;
  logic       pwr_down, delayed_timing, amp_en;
  logic [7:0] tx_gain, rx_gain, hyb_ctrl;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] mon_byte = '0;
  int         mon_n = 0;
  logic       watch_wr = 1'b0;
  logic       wr_oe_seen = 1'b0;

  always #5 cclk = ~cclk;

  ctl_serial_port i_ctl_serial_port (
    .cclk(cclk), .mr(mr), .cs_n(cs_n), .ci(ci), .co(co), .co_oe(co_oe),
    .il_in(il_in), .il_out(il_out), .il_oe(il_oe),
    .pwr_down(pwr_down), .delayed_timing(delayed_timing), .amp_en(amp_en),
    .tx_gain(tx_gain), .rx_gain(rx_gain), .hyb_ctrl(hyb_ctrl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: assemble driven bytes and compare with the scoreboard
  always @(negedge cclk) begin
    #3;
    if (watch_wr && co_oe !== 1'b0) wr_oe_seen = 1'b1;
    if (co_oe === 1'b1) begin
      mon_byte = {mon_byte[6:0], co};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) begin
          chk("R3 unexpected read byte", {24'd0, mon_byte}, 32'hFFFF_FFFF);
        end else begin
          chk(tag_q.pop_front(), {24'd0, mon_byte}, {24'd0, exp_q.pop_front()});
        end
      end
    end
  end

  task automatic send_bits(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge cclk);
      #1;
      cs_n = 1'b0;
      ci = w[15-i];
    end
  endtask

  task automatic end_xfer();
    @(negedge cclk);
    #1;
    cs_n = 1'b1;
    ci = 1'b0;
    @(negedge cclk);
    #2;
  endtask

  task automatic wr(input logic [6:0] addr, input logic [7:0] data);
    wr_oe_seen = 1'b0;
    watch_wr = 1'b1;
    send_bits({addr, 1'b0, data}, 16);
    end_xfer();
    watch_wr = 1'b0;
    chk("R4 no drive during write", {31'd0, wr_oe_seen}, 32'd0);
  endtask

  task automatic rd(input logic [6:0] addr, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send_bits({addr, 1'b1, 8'h00}, 16);
    end_xfer();
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge cclk);
    #1 mr = 1'b0;
    @(negedge cclk);
    #2;
    // R8: power-on state at the ports
    chk("R8 pwr_down", {31'd0, pwr_down}, 32'd1);
    chk("R8 delayed_timing", {31'd0, delayed_timing}, 32'd0);
    chk("R8 amp_en", {31'd0, amp_en}, 32'd0);
    chk("R8 gains", {16'd0, tx_gain, rx_gain}, 32'd0);
    chk("R8 hybrid", {24'd0, hyb_ctrl}, 32'd0);
    chk("R8 latch pins inputs", {26'd0, il_oe}, 32'd0);
    chk("R8 co_oe", {31'd0, co_oe}, 32'd0);
    rd(7'd0, 8'h80, "R8 mode read");
    rd(7'd5, 8'h00, "R8 direction read");

    // R1 R2 R10: writes accepted while powered down
    wr(7'd1, 8'h5C);
    chk("R2 tx_gain", {24'd0, tx_gain}, 32'h5C);
    wr(7'd2, 8'hA3);
    chk("R1 rx_gain", {24'd0, rx_gain}, 32'hA3);
    chk("R10 still powered down", {31'd0, pwr_down}, 32'd1);
    rd(7'd1, 8'h5C, "R3 tx_gain read");
    rd(7'd2, 8'hA3, "R3 rx_gain read");

    // R1: mode bits
    wr(7'd0, 8'h61);
    chk("R1 pwr_down cleared", {31'd0, pwr_down}, 32'd0);
    chk("R1 delayed_timing set", {31'd0, delayed_timing}, 32'd1);
    chk("R1 amp_en set", {31'd0, amp_en}, 32'd1);
    rd(7'd0, 8'h61, "R3 mode read");
    wr(7'd3, 8'h3F);
    chk("R2 hybrid", {24'd0, hyb_ctrl}, 32'h3F);

    // R5: partial frames are dropped
    send_bits({7'd1, 1'b0, 8'hFF}, 12);
    end_xfer();
    chk("R5 tx_gain after 12 bits", {24'd0, tx_gain}, 32'h5C);
    send_bits({7'd2, 1'b0, 8'h00}, 5);
    end_xfer();
    chk("R5 co_oe idle", {31'd0, co_oe}, 32'd0);
    wr(7'd2, 8'h11);
    chk("R5 fresh frame after abort", {24'd0, rx_gain}, 32'h11);

    // R11: unused address
    wr(7'h40, 8'hFF);
    chk("R11 tx unchanged", {24'd0, tx_gain}, 32'h5C);
    chk("R11 rx unchanged", {24'd0, rx_gain}, 32'h11);
    chk("R11 hybrid unchanged", {24'd0, hyb_ctrl}, 32'h3F);
    chk("R11 mode unchanged", {29'd0, pwr_down, delayed_timing, amp_en}, 32'b011);
    chk("R11 pins unchanged", {26'd0, il_oe}, 32'd0);
    rd(7'h40, 8'h00, "R11 unused read");

    // R6 R7: latch pins
    il_in = 6'b110100;
    wr(7'd5, 8'h07);
    chk("R6 il_oe", {26'd0, il_oe}, 32'h07);
    wr(7'd4, 8'h2A);
    chk("R6 il_out outputs", {29'd0, il_out[2:0]}, 32'b010);
    il_in = 6'b001000;
    rd(7'd4, 8'h0A, "R7 latch read mixes pins");
    il_in = 6'b011000;
    wr(7'd5, 8'h3F);
    chk("R6 all outputs", {26'd0, il_oe}, 32'h3F);
    chk("R7 captured inputs on il_out", {26'd0, il_out}, 32'h1A);
    rd(7'd5, 8'h3F, "R3 direction read");

    // R9: master reset in the middle of a write
    send_bits({7'd1, 1'b0, 8'hEE}, 10);
    @(negedge cclk);
    #1 mr = 1'b1;
    @(negedge cclk);
    #1 mr = 1'b0;
    cs_n = 1'b1;
    @(negedge cclk);
    #2;
    chk("R9 tx_gain default", {24'd0, tx_gain}, 32'h00);
    chk("R9 mode default", {29'd0, pwr_down, delayed_timing, amp_en}, 32'b100);
    chk("R9 pins inputs", {26'd0, il_oe}, 32'd0);
    chk("R9 hybrid default", {24'd0, hyb_ctrl}, 32'd0);
    wr(7'd1, 8'h77);
    chk("R9 frame after reset", {24'd0, tx_gain}, 32'h77);

    repeat (4) @(negedge cclk);
    chk("R3 all reads seen", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule